// File: doc/BRIEF.md
# Link Powerdown and Wake Controller

This block sits on the codec side of a serial audio link. It watches the register writes that the slot decoder has already extracted from the output frames. It also controls the two things the codec drives back onto the link: the enable for the bit clock and a force-low control for the serial input data line.

A write to the powerdown register with the link-halt bit set arms a halt. At the next frame boundary, the block stops the bit clock, holds the input data low and drops the ready flag. It leaves the register contents untouched.

Only a reset can bring the link back. A warm reset is seen as the frame-sync input held high for a minimum number of local-oscillator cycles and then released. A cold reset is the asynchronous reset pin. After either one, the clock restarts. The ready flag, which the frame builder places in bit 15 of input slot 0, rises after a fixed clock-settling count.

Top module: `acl_pd_ctrl`

## Requirements
- R1: While rst_ni is low and on its release, bit_clk_en_o is 1, sdin_low_o is 0, ready_o is 0 and pd_reg_o is 0x0000. ready_o rises after STAB_CYC clock edges.
- R2: A write to address 0x26 stores all 16 data bits, and the value is visible on pd_reg_o after the write's clock edge.
- R3: A write to 0x26 with data bit 12 set halts the link at the first frame_end_i pulse strictly after the write cycle. A frame_end_i pulse in the write cycle itself does not count. Halted means bit_clk_en_o=0, sdin_low_o=1 and ready_o=0.
- R4: A write to 0x26 with bit 12 clear never halts the link.
- R5: While halted, the outputs stay in the halted values and register writes have no effect on pd_reg_o.
- R6: When sync_i has been high for at least WARM_CYC clock edges while the link is halted, its fall restarts the bit clock at the next edge (bit_clk_en_o=1, sdin_low_o=0).
- R7: A sync_i high pulse shorter than WARM_CYC edges leaves the link halted.
- R8: After the clock restarts, ready_o stays 0 for STAB_CYC-1 edges and is 1 after the STAB_CYC-th edge.
- R9: A write to address 0x00 (any data) returns pd_reg_o to 0x0000 and cancels an armed halt.
- R10: Writes to any other address change neither pd_reg_o nor the link state.
- R11: pd_reg_o keeps its value through a halt and a warm wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running local oscillator |
| rst_ni | input | 1 | Cold reset, active low, asynchronous |
| wr_en_i | input | 1 | Decoded register write strobe |
| wr_addr_i | input | 7 | Register address of the write |
| wr_data_i | input | 16 | Register write data |
| frame_end_i | input | 1 | One-cycle pulse at each frame boundary |
| sync_i | input | 1 | Frame-sync line from the controller |
| bit_clk_en_o | output | 1 | Enable for the bit clock driver |
| sdin_low_o | output | 1 | Forces the serial input data line low |
| ready_o | output | 1 | Codec-ready flag for slot 0, bit 15 |
| pd_reg_o | output | 16 | Current powerdown register contents |

## Verification
Two events can fall in the same cycle: the decode of a halting write and a frame boundary. The bench provokes this by pulsing frame_end_i in the same cycle as a write to 0x26 with bit 12 set. It then checks that the clock is still enabled after that edge and stops only at the following boundary. A second collision arms a halt and clears it with a write to 0x00 before any boundary. The next boundary must then leave the link running.

// File: rtl/acl_pd_pkg.sv
package acl_pd_pkg;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam logic [AW-1:0] ADDR_RESET = 7'h00;
  localparam logic [AW-1:0] ADDR_PD    = 7'h26;
  localparam int HALT_BIT = 12;

  typedef enum logic [1:0] {
    LNK_STAB  = 2'd0,
    LNK_READY = 2'd1,
    LNK_HALT  = 2'd2
  } lnk_state_e;
endpackage

// File: rtl/acl_pd_regs.sv
module acl_pd_regs
  import acl_pd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          halted_i,
  output logic [DW-1:0] pd_reg_o,
  output logic          halt_req_o,
  output logic          reg_rst_o
);
  logic wr_ok;
  assign wr_ok      = wr_en_i && !halted_i;
  assign halt_req_o = wr_ok && (wr_addr_i == ADDR_PD) && wr_data_i[HALT_BIT];
  assign reg_rst_o  = wr_ok && (wr_addr_i == ADDR_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pd_reg_o <= '0;
    else if (reg_rst_o)                      pd_reg_o <= '0;
    else if (wr_ok && wr_addr_i == ADDR_PD)  pd_reg_o <= wr_data_i;
  end

  AST_REG_HELD_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> $stable(pd_reg_o)); // R5
endmodule

// File: rtl/acl_pd_warm.sv
module acl_pd_warm #(
  parameter int WARM_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halted_i,
  input  logic sync_i,
  output logic wake_o
);
  localparam int CW = $clog2(WARM_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(WARM_CYC);

  logic [CW-1:0] hi_cnt;

  assign wake_o = halted_i && !sync_i && (hi_cnt >= LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hi_cnt <= '0;
    else if (!halted_i || !sync_i)  hi_cnt <= '0;
    else if (hi_cnt != LIM)         hi_cnt <= hi_cnt + 1'b1;
  end

  AST_WAKE_AFTER_LONG_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(sync_i)); // R7
endmodule

// File: rtl/acl_pd_fsm.sv
module acl_pd_fsm
  import acl_pd_pkg::*;
#(
  parameter int STAB_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_req_i,
  input  logic reg_rst_i,
  input  logic frame_end_i,
  input  logic wake_i,
  output logic halted_o,
  output logic bit_clk_en_o,
  output logic sdin_low_o,
  output logic ready_o
);
  localparam int SW = $clog2(STAB_CYC + 1);
  localparam logic [SW-1:0] LAST = SW'(STAB_CYC - 1);

  lnk_state_e    state_q;
  logic [SW-1:0] stab_cnt;
  logic          pend_q;
  logic          go_halt;

  assign go_halt = pend_q && frame_end_i && (state_q != LNK_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= LNK_STAB;
      stab_cnt <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (go_halt)         pend_q <= 1'b0;
      else if (reg_rst_i)  pend_q <= 1'b0;
      else if (halt_req_i) pend_q <= 1'b1;
      unique case (state_q)
        LNK_STAB: begin
          if (go_halt) state_q <= LNK_HALT;
          else if (stab_cnt == LAST) state_q <= LNK_READY;
          else stab_cnt <= stab_cnt + 1'b1;
        end
        LNK_READY: if (go_halt) state_q <= LNK_HALT;
        LNK_HALT: if (wake_i) begin
          state_q  <= LNK_STAB;
          stab_cnt <= '0;
        end
        default: state_q <= LNK_STAB;
      endcase
    end
  end

  assign halted_o     = (state_q == LNK_HALT);
  assign bit_clk_en_o = !halted_o;
  assign sdin_low_o   = halted_o;
  assign ready_o      = (state_q == LNK_READY);

  AST_HALT_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bit_clk_en_o) |-> $past(frame_end_i)); // R3
  AST_RESUME_ON_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bit_clk_en_o) |-> $past(wake_i)); // R6
  AST_READY_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(bit_clk_en_o) && !$past(ready_o)); // R8
endmodule

// File: rtl/acl_pd_ctrl.sv
module acl_pd_ctrl
  import acl_pd_pkg::*;
#(
  parameter int WARM_CYC = 8,
  parameter int STAB_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          frame_end_i,
  input  logic          sync_i,
  output logic          bit_clk_en_o,
  output logic          sdin_low_o,
  output logic          ready_o,
  output logic [DW-1:0] pd_reg_o
);
  logic halted, halt_req, reg_rst, wake;

  acl_pd_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .halted_i(halted), .pd_reg_o, .halt_req_o(halt_req), .reg_rst_o(reg_rst)
  );

  acl_pd_warm #(.WARM_CYC(WARM_CYC)) u_warm (
    .clk_i, .rst_ni, .halted_i(halted), .sync_i, .wake_o(wake)
  );

  acl_pd_fsm #(.STAB_CYC(STAB_CYC)) u_fsm (
    .clk_i, .rst_ni, .halt_req_i(halt_req), .reg_rst_i(reg_rst),
    .frame_end_i, .wake_i(wake), .halted_o(halted),
    .bit_clk_en_o, .sdin_low_o, .ready_o
  );

  AST_READY_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> bit_clk_en_o && !sdin_low_o); // R5
endmodule

// File: tb/acl_pd_ctrl_tb.sv
module acl_pd_ctrl_tb;
  localparam int WARM = 8;
  localparam int STAB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, fe = 1'b0, sync = 1'b0;
  logic [6:0] addr = '0;
  logic [15:0] data = '0;
  logic clk_en, sd_low, rdy;
  logic [15:0] pd;
  int nchk = 0, nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acl_pd_ctrl #(.WARM_CYC(WARM), .STAB_CYC(STAB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(addr),
    .wr_data_i(data), .frame_end_i(fe), .sync_i(sync),
    .bit_clk_en_o(clk_en), .sdin_low_o(sd_low), .ready_o(rdy), .pd_reg_o(pd)
  );

  // {addr, data, expected pd}
  localparam logic [38:0] VEC [5] = '{
    {7'h26, 16'h0300, 16'h0300},  // R2
    {7'h26, 16'h00FF, 16'h00FF},  // R2
    {7'h10, 16'hFFFF, 16'h00FF},  // R10
    {7'h00, 16'h1234, 16'h0000},  // R9
    {7'h26, 16'hA0F0, 16'hA0F0}   // R4 bit 12 clear
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d, logic f = 1'b0);
    wr_en = 1'b1; addr = a; data = d; fe = f;
    tick();
    wr_en = 1'b0; fe = 1'b0;
  endtask

  task automatic frame();
    fe = 1'b1; tick(); fe = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nchk++; nbad++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    finish_run();
  end

  initial begin
    #25;
    chk("R1 clk_en in reset", 16'(clk_en), 16'h1);
    chk("R1 ready in reset", 16'(rdy), 16'h0);
    chk("R1 reg in reset", pd, 16'h0000);
    rst_n = 1'b1;
    tick(STAB - 1);
    chk("R1 ready before settle", 16'(rdy), 16'h0);
    tick();
    chk("R1 ready after settle", 16'(rdy), 16'h1);

    foreach (VEC[i]) begin
      wr(VEC[i][38:32], VEC[i][31:16]);
      frame();
      chk("R2/R9/R10 reg value", pd, VEC[i][15:0]);
      chk("R4/R10 link running", 16'(clk_en), 16'h1);
    end

    // R9: armed halt cancelled by register reset
    wr(7'h26, 16'h1000);
    wr(7'h00, 16'h0000);
    frame();
    chk("R9 halt cancelled", 16'(clk_en), 16'h1);
    chk("R9 reg cleared", pd, 16'h0000);

    // R3: write and frame boundary in the same cycle
    wr(7'h26, 16'h1F00, 1'b1);
    chk("R3 no halt on same-cycle frame", 16'(clk_en), 16'h1);
    tick(3);
    chk("R3 still running before boundary", 16'(clk_en), 16'h1);
    frame();
    chk("R3 clk stopped", 16'(clk_en), 16'h0);
    chk("R3 sdin forced low", 16'(sd_low), 16'h1);
    chk("R3 ready cleared", 16'(rdy), 16'h0);

    // R5: writes ignored while halted
    wr(7'h26, 16'h0000);
    wr(7'h00, 16'h0000);
    frame();
    chk("R5 reg retained", pd, 16'h1F00);
    chk("R5 still halted", 16'(clk_en), 16'h0);

    // R7: short sync pulse
    sync = 1'b1; tick(WARM - 1); sync = 1'b0; tick(3);
    chk("R7 short sync no wake", 16'(clk_en), 16'h0);
    chk("R7 sdin still low", 16'(sd_low), 16'h1);

    // R6: warm reset
    sync = 1'b1; tick(WARM);
    chk("R6 no wake while sync high", 16'(clk_en), 16'h0);
    sync = 1'b0; tick();
    chk("R6 clk resumed", 16'(clk_en), 16'h1);
    chk("R6 sdin released", 16'(sd_low), 16'h0);

    // R8: settling count
    tick(STAB - 1);
    chk("R8 ready before count", 16'(rdy), 16'h0);
    tick();
    chk("R8 ready after count", 16'(rdy), 16'h1);
    chk("R11 reg retained through wake", pd, 16'h1F00);

    finish_run();
  end
endmodule